// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every data beat of an SDRAM read or write burst. When a start strobe is accepted, the block captures three things: a 3-bit burst-length code, a 1-bit ordering select and an 8-bit starting column. From the next clock it drives one column per cycle with a valid flag, and it raises a last-beat flag on the final beat.

Two orderings are available. Sequential ordering counts the column upward and wraps it within the column width. Interleaved ordering flips the low column bits wherever the beat index has a one. A full-page code starts a sequential burst that has no fixed end. It keeps counting and wrapping until the terminate input is raised. A reserved length code produces no beats and sets an error flag instead.

Top module: `burst_col_addr`

## Requirements
- R1: Length code (bits of `modeLen`) 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of exactly 1, 2, 4 and 8 beats. `lastBeat` is high on the final beat only.
- R2: `modeInterleave` = 0 selects sequential ordering and 1 selects interleaved ordering. Both are captured on the accepted start.
- R3: In sequential ordering, beat m carries column (n + m) mod 2^COL_W, where n is the captured starting column.
- R4: In interleaved ordering with a fixed length, beat m carries n XOR m. Only the bits set in the beat index are inverted.
- R5: Code 3'b111 is full page. Columns step by one and wrap modulo 2^COL_W, and `modeInterleave` is ignored. The burst continues until `terminate` is high on a valid beat. That beat has `lastBeat` high, and `beatValid` is low on the next cycle.
- R6: Codes 3'b100, 3'b101 and 3'b110 are reserved. An accepted start with one of them produces no beat, and `modeError` is high from the next cycle. The flag stays high until the next accepted start with a legal code.
- R7: A start strobe that arrives while a burst is running is ignored. The running burst keeps its captured columns, ordering and length.
- R8: A synchronous active-high `rst` leaves `beatValid`, `lastBeat` and `modeError` low.
- R9: The first beat appears in the cycle after the accepted start and carries the starting column. Beats follow on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startIn | input | 1 | Start strobe; accepted only while idle |
| modeLen | input | 3 | Burst length code, captured on accepted start |
| modeInterleave | input | 1 | Ordering select, captured on accepted start |
| startCol | input | COL_W | Starting column, captured on accepted start |
| terminate | input | 1 | Ends a full-page burst on the current beat |
| colOut | output | COL_W | Column address of the current beat |
| beatValid | output | 1 | A beat is present on colOut |
| lastBeat | output | 1 | Current beat is the final one |
| modeError | output | 1 | Last accepted start had a reserved length code |

## Verification
The bench builds the block with its default column width of 8 bits. At that width, starting columns near 255 make the sequential wrap appear within a few beats of a short burst. A full-page run of 300 beats crosses the whole column space and returns past the starting column. Interleaved bursts of 8 beats from a start column with nonzero low bits show every inversion pattern of the three low bits.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } dpStrobe_t;

  localparam logic [2:0] LEN_FULL = 3'b111;

  function automatic logic lenIsReserved(input logic [2:0] code);
    return (code == 3'b100) || (code == 3'b101) || (code == 3'b110);
  endfunction

  function automatic logic [3:0] lenLastIdx(input logic [2:0] code);
    logic [3:0] beats;
    beats = 4'd1 << code[1:0];
    return beats - 4'd1;
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startIn,
  input  logic [2:0]       modeLenIn,
  input  logic             terminate,
  input  logic [2:0]       lenLatched,
  input  logic [COL_W-1:0] beatIdx,
  output dpStrobe_t        strb,
  output logic             busy,
  output logic             lastBeat,
  output logic             modeError
);

  logic busyQ, errQ, accept, reservedIn, fullPage;
  logic [COL_W-1:0] lastIdx;

  assign reservedIn = lenIsReserved(modeLenIn);
  assign accept     = startIn & ~busyQ;
  assign fullPage   = (lenLatched == LEN_FULL);
  assign lastIdx    = COL_W'(lenLastIdx(lenLatched));

  always_comb begin
    if (!busyQ)        lastBeat = 1'b0;
    else if (fullPage) lastBeat = terminate;
    else               lastBeat = (beatIdx == lastIdx);
  end

  always_comb begin
    strb.load = accept & ~reservedIn;
    strb.step = busyQ & ~lastBeat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      if (accept) begin
        busyQ <= ~reservedIn;
        errQ  <= reservedIn;
      end else if (lastBeat) begin
        busyQ <= 1'b0;
      end
    end
  end

  assign busy      = busyQ;
  assign modeError = errQ;

  // a running burst continues until its last beat
  assert_no_gap_R9: assert property (@(posedge clk) disable iff (rst)
    busyQ && !lastBeat |=> busyQ);

  // a start during a burst leaves the error flag untouched
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    busyQ && startIn |=> $stable(errQ));

endmodule

// File: rtl/burst_dpath.sv
module burst_dpath
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       modeLenIn,
  input  logic             interleaveIn,
  output logic [2:0]       lenLatched,
  output logic [COL_W-1:0] beatIdx,
  output logic [COL_W-1:0] colOut
);

  logic [COL_W-1:0] baseQ, idxQ;
  logic [2:0]       lenQ;
  logic             ilvQ, ilvEff;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ <= '0;
      idxQ  <= '0;
      lenQ  <= 3'b000;
      ilvQ  <= 1'b0;
    end else if (strb.load) begin
      baseQ <= startCol;
      idxQ  <= '0;
      lenQ  <= modeLenIn;
      ilvQ  <= interleaveIn;
    end else if (strb.step) begin
      idxQ  <= idxQ + 1'b1;
    end
  end

  // full page always counts upward
  assign ilvEff     = ilvQ && (lenQ != LEN_FULL);
  assign colOut     = ilvEff ? (baseQ ^ idxQ) : (baseQ + idxQ);
  assign lenLatched = lenQ;
  assign beatIdx    = idxQ;

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
    strb.step && !ilvEff |=> colOut == $past(colOut) + 1'b1);

  assert_ilv_flip_R4: assert property (@(posedge clk) disable iff (rst)
    strb.step && ilvEff |=> $countones(colOut ^ $past(colOut)) >= 1);

endmodule

// File: rtl/burst_col_addr.sv
module burst_col_addr
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startIn,
  input  logic [2:0]       modeLen,
  input  logic             modeInterleave,
  input  logic [COL_W-1:0] startCol,
  input  logic             terminate,
  output logic [COL_W-1:0] colOut,
  output logic             beatValid,
  output logic             lastBeat,
  output logic             modeError
);

  dpStrobe_t        strb;
  logic [2:0]       lenLatched;
  logic [COL_W-1:0] beatIdx;
  logic             busy;

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst(rst), .startIn(startIn), .modeLenIn(modeLen),
    .terminate(terminate), .lenLatched(lenLatched), .beatIdx(beatIdx),
    .strb(strb), .busy(busy), .lastBeat(lastBeat), .modeError(modeError)
  );

  burst_dpath #(.COL_W(COL_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .startCol(startCol),
    .modeLenIn(modeLen), .interleaveIn(modeInterleave),
    .lenLatched(lenLatched), .beatIdx(beatIdx), .colOut(colOut)
  );

  assign beatValid = busy;

  assert_first_col_R9: assert property (@(posedge clk) disable iff (rst)
    startIn && !beatValid && !lenIsReserved(modeLen) |=> beatValid && colOut == $past(startCol));

  assert_last_ends_R5: assert property (@(posedge clk) disable iff (rst)
    lastBeat |=> !beatValid);

  assert_err_silent_R6: assert property (@(posedge clk) disable iff (rst)
    modeError |-> !beatValid);

  assert_last_valid_R1: assert property (@(posedge clk) disable iff (rst)
    lastBeat |-> beatValid);

endmodule

// File: tb/test_burst_col_addr.sv
module test_burst_col_addr;

  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             startIn = 1'b0;
  logic [2:0]       modeLen = 3'b000;
  logic             modeInterleave = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic             terminate = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             beatValid, lastBeat, modeError;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_col_addr #(.COL_W(COL_W)) i_burst_col_addr (
    .clk(clk), .rst(rst), .startIn(startIn), .modeLen(modeLen),
    .modeInterleave(modeInterleave), .startCol(startCol),
    .terminate(terminate), .colOut(colOut), .beatValid(beatValid),
    .lastBeat(lastBeat), .modeError(modeError)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulseStart(input logic [2:0] code, input logic ilv,
                            input logic [COL_W-1:0] col);
    @(negedge clk);
    startIn = 1'b1; modeLen = code; modeInterleave = ilv; startCol = col;
    @(negedge clk);
    startIn = 1'b0; modeLen = 3'b000; modeInterleave = 1'b0; startCol = '0;
  endtask

  // R1 R2 R3 R4 R9: fixed-length burst, checks every beat then the idle cycle
  task automatic fixedBurst(input logic [2:0] code, input logic ilv,
                            input logic [COL_W-1:0] col, input string req);
    int beats = 1 << code;
    pulseStart(code, ilv, col);
    for (int m = 0; m < beats; m++) begin
      logic [COL_W-1:0] exp;
      exp = ilv ? (col ^ COL_W'(m)) : (col + COL_W'(m));
      if (m > 0) @(negedge clk);
      check(beatValid === 1'b1, req, "valid", beatValid, 1);
      check(colOut === exp, req, "column", colOut, exp);
      check(lastBeat === (m == beats - 1), "R1", "last flag", lastBeat, m == beats - 1);
    end
    @(negedge clk);
    check(beatValid === 1'b0, "R1", "valid after burst", beatValid, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(beatValid === 1'b0, "R8", "valid in reset", beatValid, 0);
    check(lastBeat === 1'b0, "R8", "last in reset", lastBeat, 0);
    check(modeError === 1'b0, "R8", "error in reset", modeError, 0);
  endtask

  task automatic testFullPage(input logic [COL_W-1:0] col, input logic ilv, input int beats);
    pulseStart(3'b111, ilv, col);
    for (int m = 0; m < beats; m++) begin
      logic [COL_W-1:0] exp;
      exp = col + COL_W'(m);
      if (m > 0) @(negedge clk);
      if (m == beats - 1) terminate = 1'b1;
      #0.1;
      check(beatValid === 1'b1, "R5", "full page valid", beatValid, 1);
      check(colOut === exp, "R5", "full page column", colOut, exp);
      check(lastBeat === (m == beats - 1), "R5", "full page last", lastBeat, m == beats - 1);
    end
    @(negedge clk);
    terminate = 1'b0;
    check(beatValid === 1'b0, "R5", "valid after terminate", beatValid, 0);
  endtask

  task automatic testReserved(input logic [2:0] code);
    pulseStart(code, 1'b0, 8'd5);
    for (int k = 0; k < 3; k++) begin
      check(beatValid === 1'b0, "R6", "no beat on reserved", beatValid, 0);
      check(modeError === 1'b1, "R6", "error flag", modeError, 1);
      @(negedge clk);
    end
    fixedBurst(3'b001, 1'b0, 8'd40, "R6");
    check(modeError === 1'b0, "R6", "error cleared", modeError, 0);
  endtask

  task automatic testStartDuring();
    pulseStart(3'b010, 1'b0, 8'd10);
    check(colOut === 8'd10, "R7", "beat 0", colOut, 10);
    startIn = 1'b1; modeLen = 3'b011; modeInterleave = 1'b1; startCol = 8'd200;
    @(negedge clk);
    startIn = 1'b0; modeLen = 3'b000; modeInterleave = 1'b0; startCol = '0;
    for (int m = 1; m < 4; m++) begin
      if (m > 1) @(negedge clk);
      check(colOut === 8'(10 + m), "R7", "column kept", colOut, 10 + m);
      check(beatValid === 1'b1, "R7", "valid kept", beatValid, 1);
      check(lastBeat === (m == 3), "R7", "length kept", lastBeat, m == 3);
    end
    @(negedge clk);
    check(beatValid === 1'b0, "R7", "ends at original length", beatValid, 0);
  endtask

  task automatic testIdleTerminate();
    @(negedge clk);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    check(beatValid === 1'b0, "R5", "terminate idle no effect", beatValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    fixedBurst(3'b000, 1'b0, 8'd7,   "R1");
    fixedBurst(3'b001, 1'b0, 8'd255, "R3");
    fixedBurst(3'b010, 1'b0, 8'd30,  "R1");
    fixedBurst(3'b011, 1'b0, 8'd252, "R3");
    fixedBurst(3'b010, 1'b1, 8'd6,   "R4");
    fixedBurst(3'b011, 1'b1, 8'd13,  "R4");
    fixedBurst(3'b011, 1'b1, 8'd255, "R2");
    fixedBurst(3'b001, 1'b1, 8'd128, "R2");
    testFullPage(8'd250, 1'b0, 300);
    testFullPage(8'd3, 1'b1, 12);
    testReserved(3'b100);
    testReserved(3'b101);
    testReserved(3'b110);
    testStartDuring();
    testIdleTerminate();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule